// File: doc/BRIEF.md
# Manchester Fieldbus Frame Receiver

This block listens to a Manchester II coded fieldbus line and turns what it hears into frame records. The system clock runs at a multiple of the bit rate (set by `OVS`, the number of samples per bit cell). A timing recovery stage re-aligns to every transition on the line, samples each half cell in its centre, and reports a timing fault when a transition lands well away from a half-cell boundary. A framer groups half cells into symbol pairs. It uses the deliberately invalid symbols in the opening four cells to tell a master frame from a slave frame. It then collects data bits and closes the frame when the line has been quiet for longer than one and a half bit cells.

At frame close the framer checks the received length against the lengths allowed for the frame type and verifies the trailing check byte. It writes one record into a small receive queue: the data field left-aligned in 64 bits, plus a status byte. Each fault class has its own flag in that byte. A level-triggered interrupt rises once the queue holds at least the number of records set on `trig_i`. The block has no output toward the line, so it cannot disturb bus traffic.

Top module: `mfr_rx`

## Requirements
- R1: After reset the queue is empty: `rec_vld_o` = 0, `fill_o` = 0, `irq_o` = 0.
- R2: The idle line is low. A data 1 is sent as high-then-low and a data 0 as low-then-high. A frame starts with four cells: 1, high-high, low-low, 0 for a master frame, or 1, low-low, high-high, 1 for a slave frame. A master frame with 16 data bits and a correct check byte is stored with data in bits 63:48 (first bit received at bit 63), zeros below, and status 8'h00.
- R3: A slave frame with 16, 32 or 64 data bits and a correct check byte is stored with status bit 7 = 1, size code in bits 6:5 (0, 1 or 2 respectively), no flags, and data left-aligned.
- R4: A frame whose four opening cells match neither pattern is stored with delimiter flag bit 3 set and size code 3.
- R5: A cell inside the data or check field whose two halves carry equal levels sets coding flag bit 2.
- R6: A frame with a valid opening whose bit count after the opening differs from 24 (master) or 24/40/72 (slave) sets length flag bit 1 and size code 3, and stored data is zero.
- R7: The 8 bits after the data field are a CRC-7 (polynomial x^7+x^6+x^5+x^2+1, initial value 0, data first bit first) in bits 7:1 and the XOR of those 7 bits in bit 0, sent most significant first. A mismatch on a correctly sized frame sets check flag bit 0. The length and check flags are never set together.
- R8: A transition arriving more than OVS/8 samples away from the expected half-cell boundary sets sync flag bit 4 for the frame.
- R9: A frame closes after about 1.75 bit cells without transitions. Consecutive frames separated by such a gap are each stored as separate records.
- R10: Records are read oldest first; a `rd_i` pulse removes the head. With the queue holding `DEPTH` records, further frames are discarded and the stored ones are kept.
- R11: `irq_o` is high exactly when the queue holds at least one record and at least `trig_i` records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Received bus line level (asynchronous) |
| trig_i | input | $clog2(DEPTH+1) | Queue fill level that raises the interrupt |
| rd_i | input | 1 | Remove the head record |
| rec_data_o | output | 64 | Head record data field, left-aligned |
| rec_stat_o | output | 8 | Head record status: [7] slave, [6:5] size, [4] sync, [3] delimiter, [2] coding, [1] length, [0] check |
| rec_vld_o | output | 1 | Queue holds at least one record |
| fill_o | output | $clog2(DEPTH+1) | Number of stored records |
| irq_o | output | 1 | Fill level interrupt |

## Verification
The in-line assertions check, on every cycle, that the queue count never passes its depth, that a push into a full queue leaves the count unchanged, that an accepted push raises the count by one, that a frame start is only seen while the framer is idle, and that a closing frame never carries both the length and the check flag. Whether the right bits, size code and individual fault flag come out of a given line waveform can only be shown by the bench scenarios. These include the delimiter patterns, an injected invalid symbol, a stretched half cell, a bad length and a corrupted check byte, together with ordering, overflow and interrupt level.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

   localparam int DATA_MAX = 64;
   localparam int CHK_W    = 8;
   localparam int BUF_W    = DATA_MAX + CHK_W;
   localparam int OPEN_CELLS = 4;

   // Opening patterns as pair codes {first half, second half}
   localparam logic [7:0] OPEN_MASTER = 8'b10_11_00_01;
   localparam logic [7:0] OPEN_SLAVE  = 8'b10_00_11_10;

   localparam logic [6:0] CRC_POLY = 7'h65;

   typedef struct packed {
      logic       slave;
      logic [1:0] size;
      logic       f_sync;
      logic       f_open;
      logic       f_code;
      logic       f_len;
      logic       f_chk;
   } stat_t;

   typedef struct packed {
      logic [DATA_MAX-1:0] data;
      stat_t               st;
   } rec_t;

   function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
      logic fb;
      fb = c[6] ^ b;
      return {c[5:0], 1'b0} ^ (fb ? CRC_POLY : 7'h00);
   endfunction

endpackage

// File: rtl/mfr_halfcell.sv
module mfr_halfcell #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic hv_o,
   output logic hl_o,
   output logic edge_o,
   output logic start_o,
   output logic end_o,
   output logic serr_o,
   output logic busy_o
);
   localparam int HALF = OVS / 2;
   localparam int QTR  = OVS / 4;
   localparam int TOL  = OVS / 8;
   localparam int GAP  = OVS + HALF + QTR;
   localparam int CW   = $clog2(HALF);
   localparam int SW   = $clog2(GAP + 1);

   generate
      if (OVS < 8 || (OVS % 8) != 0) begin : g_bad_ovs
         $error("mfr_halfcell: OVS must be a multiple of 8");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic          lvl_q;
   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [SW-1:0] sil_q;
   logic          chg;

   assign chg     = sync_q[1] ^ lvl_q;
   assign hl_o    = sync_q[1];
   assign busy_o  = busy_q;
   assign start_o = !busy_q && chg && sync_q[1];
   assign edge_o  = busy_q && chg;
   assign hv_o    = busy_q && !chg && (cnt_q == CW'(QTR));
   assign end_o   = busy_q && !chg && (sil_q == SW'(GAP - 1));
   assign serr_o  = busy_q && chg && (cnt_q > CW'(TOL)) && (cnt_q < CW'(HALF - TOL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         lvl_q  <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
         sil_q  <= '0;
      end else begin
         sync_q <= {sync_q[0], line_i};
         lvl_q  <= sync_q[1];
         if (!busy_q) begin
            if (chg && sync_q[1]) begin
               busy_q <= 1'b1;
               cnt_q  <= CW'(1);
               sil_q  <= SW'(1);
            end
         end else if (chg) begin
            cnt_q <= CW'(1);
            sil_q <= SW'(1);
         end else if (end_o) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= (cnt_q == CW'(HALF - 1)) ? '0 : cnt_q + CW'(1);
            sil_q <= sil_q + SW'(1);
         end
      end
   end

   assert_start_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> busy_o);

endmodule

// File: rtl/mfr_framer.sv
module mfr_framer
   import mfr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hv_i,
   input  logic hl_i,
   input  logic edge_i,
   input  logic start_i,
   input  logic end_i,
   input  logic serr_i,
   output logic push_o,
   output rec_t rec_o
);
   logic             busy_q, first_q, viol_q, sync_q, snapv_q;
   logic [7:0]       hs_q, snap_q, open_q;
   logic [BUF_W-1:0] buf_q;
   logic [6:0]       crc_q;
   logic [6:0]       crcs_q [3];
   logic [6:0]       pair, di;

   assign pair = hs_q[7:1];
   assign di   = pair - 7'(OPEN_CELLS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; first_q <= 1'b0; viol_q <= 1'b0; sync_q <= 1'b0;
         snapv_q <= 1'b0; hs_q <= '0; snap_q <= '0; open_q <= '0;
         buf_q <= '0; crc_q <= '0;
         for (int k = 0; k < 3; k++) crcs_q[k] <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1; first_q <= 1'b0; viol_q <= 1'b0; sync_q <= 1'b0;
         snapv_q <= 1'b0; hs_q <= '0; snap_q <= '0; open_q <= '0;
         buf_q <= '0; crc_q <= '0;
         for (int k = 0; k < 3; k++) crcs_q[k] <= '0;
      end else if (busy_q) begin
         if (serr_i) sync_q <= 1'b1;
         if (edge_i) begin
            snap_q  <= 8'((9'(hs_q) + 9'd1) >> 1);
            snapv_q <= viol_q;
         end
         if (hv_i) begin
            hs_q <= (hs_q == 8'hFF) ? hs_q : hs_q + 8'd1;
            if (!hs_q[0]) begin
               first_q <= hl_i;
            end else if (pair < 7'(OPEN_CELLS)) begin
               open_q <= {open_q[5:0], first_q, hl_i};
            end else begin
               if (di < 7'(BUF_W)) buf_q[di] <= first_q;
               if (first_q == hl_i) viol_q <= 1'b1;
               for (int k = 0; k < 3; k++)
                  if (di == 7'(16 << k)) crcs_q[k] <= crc_q;
               crc_q <= crc_step(crc_q, first_q);
            end
         end
         if (end_i) busy_q <= 1'b0;
      end
   end

   // Frame close evaluation
   logic [7:0] ntot;
   logic       is_m, is_s, open_ok, len_ok;
   logic [1:0] size;
   logic [7:0] rx_chk [3];
   logic [7:0] rx_sel, exp_sel;
   logic [6:0] crc_sel;
   int         nd;

   assign ntot    = (snap_q < 8'(OPEN_CELLS)) ? 8'd0 : snap_q - 8'(OPEN_CELLS);
   assign is_m    = (open_q == OPEN_MASTER);
   assign is_s    = (open_q == OPEN_SLAVE);
   assign open_ok = is_m || is_s;
   assign len_ok  = open_ok && (size != 2'd3);

   always_comb begin
      size = 2'd3;
      if (is_m && ntot == 8'd24) size = 2'd0;
      else if (is_s) begin
         case (ntot)
            8'd24:   size = 2'd0;
            8'd40:   size = 2'd1;
            8'd72:   size = 2'd2;
            default: size = 2'd3;
         endcase
      end
   end

   genvar gs, gb;
   generate
      for (gs = 0; gs < 3; gs++) begin : g_chk
         for (gb = 0; gb < CHK_W; gb++) begin : g_bit
            assign rx_chk[gs][CHK_W-1-gb] = buf_q[(16 << gs) + gb];
         end
      end
   endgenerate

   always_comb begin
      case (size)
         2'd0:    begin crc_sel = crcs_q[0]; rx_sel = rx_chk[0]; nd = 16; end
         2'd1:    begin crc_sel = crcs_q[1]; rx_sel = rx_chk[1]; nd = 32; end
         2'd2:    begin crc_sel = crcs_q[2]; rx_sel = rx_chk[2]; nd = 64; end
         default: begin crc_sel = '0;        rx_sel = '0;        nd = 0;  end
      endcase
      exp_sel = {crc_sel, ^crc_sel};
   end

   generate
      for (gb = 0; gb < DATA_MAX; gb++) begin : g_data
         assign rec_o.data[DATA_MAX-1-gb] = len_ok && (gb < nd) && buf_q[gb];
      end
   endgenerate

   assign rec_o.st.slave  = is_s;
   assign rec_o.st.size   = size;
   assign rec_o.st.f_sync = sync_q;
   assign rec_o.st.f_open = !open_ok;
   assign rec_o.st.f_code = snapv_q;
   assign rec_o.st.f_len  = open_ok && !len_ok;
   assign rec_o.st.f_chk  = len_ok && (rx_sel != exp_sel);
   assign push_o          = busy_q && end_i;

   assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q);
   assert_close_frees_framer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !busy_q);
   assert_len_chk_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> !(rec_o.st.f_len && rec_o.st.f_chk));
   assert_sample_not_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hv_i |-> !edge_i);

endmodule

// File: rtl/mfr_rxfifo.sv
module mfr_rxfifo #(
   parameter int DEPTH = 4,
   parameter int W     = 72,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [W-1:0]  din_i,
   input  logic          pop_i,
   input  logic [CW-1:0] trig_i,
   output logic [W-1:0]  dout_o,
   output logic          vld_o,
   output logic [CW-1:0] fill_o,
   output logic          irq_o
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mfr_rxfifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          full, do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din_i;
   end

   assign dout_o = mem[rp_q];
   assign vld_o  = (cnt_q != '0);
   assign fill_o = cnt_q;
   assign irq_o  = (cnt_q != '0) && (cnt_q >= trig_i);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i) |=> $stable(cnt_q));
   assert_push_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && !do_pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/mfr_rx.sv
module mfr_rx
   import mfr_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_i,
   input  logic [CW-1:0] trig_i,
   input  logic          rd_i,
   output logic [63:0]   rec_data_o,
   output logic [7:0]    rec_stat_o,
   output logic          rec_vld_o,
   output logic [CW-1:0] fill_o,
   output logic          irq_o
);
   logic hv, hl, edg, start, fin, serr, busy, push;
   rec_t rec_in, rec_out;

   mfr_halfcell #(.OVS(OVS)) i_halfcell (
      .clk(clk), .rst_n(rst_n), .line_i(line_i),
      .hv_o(hv), .hl_o(hl), .edge_o(edg), .start_o(start),
      .end_o(fin), .serr_o(serr), .busy_o(busy)
   );

   mfr_framer i_framer (
      .clk(clk), .rst_n(rst_n), .hv_i(hv), .hl_i(hl), .edge_i(edg),
      .start_i(start), .end_i(fin), .serr_i(serr),
      .push_o(push), .rec_o(rec_in)
   );

   mfr_rxfifo #(.DEPTH(DEPTH), .W($bits(rec_t))) i_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(rec_in),
      .pop_i(rd_i), .trig_i(trig_i), .dout_o(rec_out),
      .vld_o(rec_vld_o), .fill_o(fill_o), .irq_o(irq_o)
   );

   assign rec_data_o = rec_out.data;
   assign rec_stat_o = rec_out.st;

   assert_close_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> busy);

endmodule

// File: tb/test_mfr_rx.sv
module test_mfr_rx;
   localparam int OVS   = 16;
   localparam int DEPTH = 4;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int HALF  = OVS / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line = 1'b0;
   logic [CW-1:0] trig = CW'(2);
   logic          rd = 1'b0;
   logic [63:0]   rdata;
   logic [7:0]    rstat;
   logic          rvld, irq;
   logic [CW-1:0] fill;

   int n_chk = 0, n_fail = 0;
   int seq [0:99];
   int seqn = 0;
   bit done = 0;

   always #10 clk = ~clk;

   mfr_rx #(.OVS(OVS), .DEPTH(DEPTH)) i_mfr_rx (
      .clk(clk), .rst_n(rst_n), .line_i(line), .trig_i(trig), .rd_i(rd),
      .rec_data_o(rdata), .rec_stat_o(rstat), .rec_vld_o(rvld),
      .fill_o(fill), .irq_o(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] chk8(input logic [63:0] d, input int nd);
      logic [6:0] c = '0;
      for (int i = 0; i < nd; i++) begin
         logic fb = c[6] ^ d[63-i];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h65 : 7'h00);
      end
      return {c, ^c};
   endfunction

   task automatic put(input int c);
      seq[seqn] = c;
      seqn++;
   endtask

   // cell codes: 0 = data 0, 1 = data 1, 2 = high-high, 3 = low-low
   task automatic build(input bit sl, input logic [63:0] d, input int nd, input bit flip);
      logic [7:0] c;
      seqn = 0;
      put(1);
      if (sl) begin put(3); put(2); put(1); end
      else    begin put(2); put(3); put(0); end
      for (int i = 0; i < nd; i++) put(int'(d[63-i]));
      c = chk8(d, nd) ^ {7'b0, flip};
      for (int b = 7; b >= 0; b--) put(int'(c[b]));
   endtask

   task automatic send(input int stretch);
      for (int c = 0; c < seqn; c++) begin
         logic h1, h2;
         case (seq[c])
            0: begin h1 = 1'b0; h2 = 1'b1; end
            1: begin h1 = 1'b1; h2 = 1'b0; end
            2: begin h1 = 1'b1; h2 = 1'b1; end
            default: begin h1 = 1'b0; h2 = 1'b0; end
         endcase
         line = h1;
         repeat ((c == stretch) ? HALF + 4 : HALF) @(negedge clk);
         line = h2;
         repeat (HALF) @(negedge clk);
      end
      line = 1'b0;
      repeat (64) @(negedge clk);
   endtask

   task automatic pop1;
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1", "vld", 64'(rvld), 64'd0);
      check("R1", "fill", 64'(fill), 64'd0);
      check("R1", "irq", 64'(irq), 64'd0);
   endtask

   task automatic t_master;
      logic [63:0] d = {16'hA5C3, 48'h0};
      build(0, d, 16, 0); send(-1);
      check("R2", "fill", 64'(fill), 64'd1);
      check("R2", "data", rdata, d);
      check("R2", "stat", 64'(rstat), 64'h00);
      pop1();
   endtask

   task automatic t_slaves;
      logic [63:0] d16 = {16'h3C5A, 48'h0};
      logic [63:0] d32 = {32'hDEAD_B00F, 32'h0};
      logic [63:0] d64 = 64'h0123_4567_89AB_CDEF;
      build(1, d16, 16, 0); send(-1);
      check("R3", "slave16 data", rdata, d16);
      check("R3", "slave16 stat", 64'(rstat), 64'h80);
      pop1();
      build(1, d32, 32, 0); send(-1);
      check("R3", "slave32 data", rdata, d32);
      check("R3", "slave32 stat", 64'(rstat), 64'hA0);
      pop1();
      build(1, d64, 64, 0); send(-1);
      check("R3", "slave64 data", rdata, d64);
      check("R3", "slave64 stat", 64'(rstat), 64'hC0);
      pop1();
   endtask

   task automatic t_open_err;
      build(0, {16'h1234, 48'h0}, 16, 0);
      seq[1] = 0; seq[2] = 0; seq[3] = 0;
      send(-1);
      check("R4", "stored", 64'(rvld), 64'd1);
      check("R4", "open flag", 64'(rstat[3]), 64'd1);
      check("R4", "size", 64'(rstat[6:5]), 64'd3);
      pop1();
   endtask

   task automatic t_code_err;
      build(0, {16'hA5C3, 48'h0}, 16, 0);
      seq[9] = 1; seq[10] = 2; seq[11] = 0;
      send(-1);
      check("R5", "coding flag", 64'(rstat[2]), 64'd1);
      check("R5", "no open flag", 64'(rstat[3]), 64'd0);
      pop1();
   endtask

   task automatic t_len_err;
      build(1, {20'hABCDE, 44'h0}, 20, 0); send(-1);
      check("R6", "length flag", 64'(rstat[1]), 64'd1);
      check("R6", "size", 64'(rstat[6:5]), 64'd3);
      check("R6", "check flag clear", 64'(rstat[0]), 64'd0);
      check("R6", "data zero", rdata, 64'd0);
      pop1();
   endtask

   task automatic t_chk_err;
      build(0, {16'h5A0F, 48'h0}, 16, 1); send(-1);
      check("R7", "stat", 64'(rstat), 64'h01);
      pop1();
   endtask

   task automatic t_sync_err;
      build(0, {16'hA5C3, 48'h0}, 16, 0);
      send(6);
      check("R8", "sync flag", 64'(rstat[4]), 64'd1);
      pop1();
   endtask

   task automatic t_order;
      logic [63:0] a = {16'h1111, 48'h0};
      logic [63:0] b = {32'h2222_3333, 32'h0};
      build(0, a, 16, 0); send(-1);
      build(1, b, 32, 0); send(-1);
      check("R9", "two records", 64'(fill), 64'd2);
      check("R10", "head first", rdata, a);
      pop1();
      check("R10", "head second", rdata, b);
      check("R10", "second stat", 64'(rstat), 64'hA0);
      pop1();
      check("R10", "emptied", 64'(fill), 64'd0);
   endtask

   task automatic t_irq;
      trig = CW'(2);
      build(0, {16'h0F0F, 48'h0}, 16, 0); send(-1);
      check("R11", "irq below level", 64'(irq), 64'd0);
      build(0, {16'hF0F0, 48'h0}, 16, 0); send(-1);
      check("R11", "irq at level", 64'(irq), 64'd1);
      pop1();
      check("R11", "irq after pop", 64'(irq), 64'd0);
      pop1();
   endtask

   task automatic t_full;
      for (int k = 0; k < DEPTH + 1; k++) begin
         build(0, {16'(k + 1), 48'h0}, 16, 0);
         send(-1);
      end
      check("R10", "full fill", 64'(fill), 64'(DEPTH));
      for (int k = 0; k < DEPTH; k++) begin
         check("R10", "full order", rdata, {16'(k + 1), 48'h0});
         pop1();
      end
      check("R10", "drained", 64'(rvld), 64'd0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_master();
      t_slaves();
      t_open_err();
      t_code_err();
      t_len_err();
      t_chk_err();
      t_sync_err();
      t_order();
      t_irq();
      t_full();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule